// File: doc/BRIEF.md
# Precision Time-of-Day Clock

This block keeps a free-running time of day for packet timestamping. It holds whole seconds (32 bits), nanoseconds (32 bits, always below one billion), and a binary fraction of a nanosecond (`FRAC_W` bits). On every clock cycle it adds a rate step to the nanosecond-plus-fraction accumulator. The step is a fixed nominal increment, trimmed faster or slower by a sign-and-magnitude adjust word. When nanoseconds pass 999,999,999, the nanosecond field wraps and one second is carried. The live seconds and nanoseconds drive a timestamp output that capture logic can sample every cycle.

Software reaches the clock through four word registers with a one-cycle registered read path.

- **Reading time.** A read of the fraction register copies seconds and nanoseconds into shadow registers, so that the nanosecond and seconds reads that follow return one coherent instant. The read side is a two-state machine: `RS_LIVE` moves to `RS_HELD` on a fraction read. It returns to `RS_LIVE` on a seconds read. A fraction read made in `RS_HELD` stays in `RS_HELD` and takes a fresh snapshot.
- **Setting time.** A nanosecond write is parked and only takes effect together with the seconds write. The write side is a two-state machine: `WS_IDLE` moves to `WS_ARMED` on a nanosecond write. It returns to `WS_IDLE` on a seconds write, which commits the whole time in one edge.
- **Stepping time.** Software steps the time by reading it, adding an offset and writing the result back.

Top module: `tod_clock`

## Requirements
- R1: While reset is held and after its release, seconds, nanoseconds, fraction and the adjust word are zero. `ts_sec`, `ts_ns` and `reg_rdata` read zero under reset.
- R2: With the adjust word at zero, each cycle adds `NOM_NS` nanoseconds plus `NOM_FRAC` fraction units (units of 2^-FRAC_W ns). A fraction overflow carries into nanoseconds.
- R3: Nanoseconds wrap from 999,999,999 to 0 and carry one into seconds. Seconds wrap modulo 2^32.
- R4: Adjust word: bit 31 is the sign (1 = slower) and bits 30:0 are a magnitude in fraction units. The step becomes nominal plus or minus that magnitude. A slow-down larger than nominal gives a step of zero, so time holds still.
- R5: Register addresses are 0 = fraction, 1 = nanoseconds, 2 = seconds, 3 = adjust. A fraction read latches seconds and nanoseconds. Later nanosecond and seconds reads return the latched pair, however many cycles later they come.
- R6: A seconds read releases the latch, so the next nanosecond read returns the live value. A second fraction read, made before the release, replaces the snapshot.
- R7: A nanosecond write leaves the running time untouched until the seconds write. The seconds write then loads, in one edge:
  - seconds from the seconds write;
  - nanoseconds from the parked write;
  - the fraction last written since the previous commit, or zero if there was none.
- R8: A seconds write with no parked nanosecond value replaces only the seconds field. Nanoseconds and fraction keep counting.
- R9: Read data appears on `reg_rdata` in the cycle after the read strobe. The adjust register reads back the value last written.
- R10: `ts_sec` and `ts_ns` show the live time registers in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select (0 frac, 1 ns, 2 sec, 3 adjust) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ts_sec | output | 32 | Live seconds |
| ts_ns | output | 32 | Live nanoseconds |

## Verification
Each kind of wrong internal state shows up at the ports, and most of them within a cycle or two:

- **Accumulator step.** A wrong step shows on `ts_ns` the very next cycle, and grows with every cycle that follows. A bad carry into nanoseconds also shows within a cycle.
- **Read-side state.** A read machine stuck in the wrong state only appears on the next nanosecond or seconds read. A dropped snapshot likewise waits for that read. The bench therefore leaves long gaps between the fraction read and its follow-up reads.
- **Write-side state.** A write machine stuck in `WS_ARMED` or `WS_IDLE` is caught at the seconds write. One edge later, `ts_ns` shows either a torn value or a value that should not have moved.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam logic [31:0] BILLION = 32'd1_000_000_000;

    typedef enum logic [1:0] {
        SEL_FRAC = 2'd0,
        SEL_NS   = 2'd1,
        SEL_SEC  = 2'd2,
        SEL_ADJ  = 2'd3
    } regsel_e;

    typedef enum logic {
        RS_LIVE = 1'b0,
        RS_HELD = 1'b1
    } rd_state_e;

    typedef enum logic {
        WS_IDLE  = 1'b0,
        WS_ARMED = 1'b1
    } wr_state_e;
endpackage

// File: rtl/tod_rate.sv
module tod_rate #(
    parameter int FRAC_W   = 16,
    parameter int NOM_NS   = 5,
    parameter int NOM_FRAC = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  adj_we,
    input  logic [31:0]           adj_wdata,
    output logic [31:0]           adj_q,
    output logic [32+FRAC_W-1:0]  step
);
    localparam int T_W = 32 + FRAC_W;
    localparam logic [T_W-1:0] NOM_INC =
        T_W'((64'(NOM_NS) << FRAC_W) + 64'(NOM_FRAC));

    logic [T_W-1:0] mag;

    always_ff @(posedge clk) begin
        if (rst)         adj_q <= '0;
        else if (adj_we) adj_q <= adj_wdata;
    end

    always_comb begin
        mag = {{(T_W-31){1'b0}}, adj_q[30:0]};
        if (adj_q[31]) step = (mag > NOM_INC) ? '0 : NOM_INC - mag;
        else           step = NOM_INC + mag;
    end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int FRAC_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [32+FRAC_W-1:0]  step,
    input  logic                  ld_all,
    input  logic                  ld_sec_only,
    input  logic [31:0]           ld_sec,
    input  logic [31:0]           ld_ns,
    input  logic [FRAC_W-1:0]     ld_frac,
    output logic [31:0]           sec_q,
    output logic [31:0]           ns_q,
    output logic [FRAC_W-1:0]     frac_q
);
    localparam int T_W = 32 + FRAC_W;

    logic [T_W:0]        sum;
    logic [32:0]         ns_sum;
    logic                wrap;
    logic [31:0]         ns_n;
    logic [31:0]         sec_n;
    logic [FRAC_W-1:0]   frac_n;

    always_comb begin
        sum    = {1'b0, ns_q, frac_q} + {1'b0, step};
        ns_sum = sum[T_W:FRAC_W];
        frac_n = sum[FRAC_W-1:0];
        wrap   = ns_sum >= {1'b0, BILLION};
        ns_n   = wrap ? 32'(ns_sum - {1'b0, BILLION}) : ns_sum[31:0];
        sec_n  = wrap ? sec_q + 32'd1 : sec_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q  <= '0;
            ns_q   <= '0;
            frac_q <= '0;
        end else if (ld_all) begin
            sec_q  <= ld_sec;
            ns_q   <= ld_ns;
            frac_q <= ld_frac;
        end else begin
            sec_q  <= ld_sec_only ? ld_sec : sec_n;
            ns_q   <= ns_n;
            frac_q <= frac_n;
        end
    end
endmodule

// File: rtl/tod_wrseq.sv
module tod_wrseq
    import tod_pkg::*;
#(
    parameter int FRAC_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  regsel_e            sel,
    input  logic [31:0]        wdata,
    output wr_state_e          state,
    output logic [31:0]        pend_ns,
    output logic [FRAC_W-1:0]  pend_frac,
    output logic               ld_all,
    output logic               ld_sec_only,
    output logic               adj_we
);
    wr_state_e state_n;

    always_ff @(posedge clk) begin
        if (rst) state <= WS_IDLE;
        else     state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_ns   <= '0;
            pend_frac <= '0;
        end else begin
            if (wr_en && sel == SEL_NS)
                pend_ns <= wdata;
            if (wr_en && sel == SEL_FRAC)
                pend_frac <= wdata[FRAC_W-1:0];
            else if (ld_all)
                pend_frac <= '0;
        end
    end

    always_comb begin
        state_n     = state;
        ld_all      = 1'b0;
        ld_sec_only = 1'b0;
        adj_we      = wr_en && sel == SEL_ADJ;
        unique case (state)
            WS_IDLE: begin
                if (wr_en && sel == SEL_NS)
                    state_n = WS_ARMED;
                else if (wr_en && sel == SEL_SEC)
                    ld_sec_only = 1'b1;
            end
            WS_ARMED: begin
                if (wr_en && sel == SEL_SEC) begin
                    ld_all  = 1'b1;
                    state_n = WS_IDLE;
                end
            end
        endcase
    end
endmodule

// File: rtl/tod_rdsnap.sv
module tod_rdsnap
    import tod_pkg::*;
#(
    parameter int FRAC_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  regsel_e            sel,
    input  logic [31:0]        live_sec,
    input  logic [31:0]        live_ns,
    input  logic [FRAC_W-1:0]  live_frac,
    input  logic [31:0]        adj_q,
    output rd_state_e          state,
    output logic [31:0]        shadow_sec,
    output logic [31:0]        shadow_ns,
    output logic [31:0]        rdata
);
    rd_state_e   state_n;
    logic        take_snap;
    logic [31:0] rdata_n;

    always_ff @(posedge clk) begin
        if (rst) state <= RS_LIVE;
        else     state <= state_n;
    end

    always_comb begin
        state_n   = state;
        take_snap = rd_en && sel == SEL_FRAC;
        unique case (state)
            RS_LIVE: if (take_snap) state_n = RS_HELD;
            RS_HELD: if (rd_en && sel == SEL_SEC) state_n = RS_LIVE;
        endcase
    end

    always_comb begin
        unique case (sel)
            SEL_FRAC: rdata_n = 32'(live_frac);
            SEL_NS:   rdata_n = (state == RS_HELD) ? shadow_ns : live_ns;
            SEL_SEC:  rdata_n = (state == RS_HELD) ? shadow_sec : live_sec;
            SEL_ADJ:  rdata_n = adj_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_sec <= '0;
            shadow_ns  <= '0;
            rdata      <= '0;
        end else begin
            if (take_snap) begin
                shadow_sec <= live_sec;
                shadow_ns  <= live_ns;
            end
            if (rd_en) rdata <= rdata_n;
        end
    end
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int FRAC_W   = 16,
    parameter int NOM_NS   = 5,
    parameter int NOM_FRAC = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [31:0] ts_sec,
    output logic [31:0] ts_ns
);
    localparam int T_W = 32 + FRAC_W;

    regsel_e             sel;
    logic [T_W-1:0]      step;
    logic [31:0]         adj_q;
    logic                adj_we;
    logic                ld_all;
    logic                ld_sec_only;
    logic [31:0]         pend_ns;
    logic [FRAC_W-1:0]   pend_frac;
    logic [FRAC_W-1:0]   frac_q;
    logic [31:0]         shadow_sec;
    logic [31:0]         shadow_ns;
    wr_state_e           wr_state;
    rd_state_e           rd_state;

    assign sel = regsel_e'(reg_addr);

    tod_rate #(.FRAC_W(FRAC_W), .NOM_NS(NOM_NS), .NOM_FRAC(NOM_FRAC)) u_rate (
        .clk(clk), .rst(rst), .adj_we(adj_we), .adj_wdata(reg_wdata),
        .adj_q(adj_q), .step(step)
    );

    tod_wrseq #(.FRAC_W(FRAC_W)) u_wrseq (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .sel(sel), .wdata(reg_wdata),
        .state(wr_state), .pend_ns(pend_ns), .pend_frac(pend_frac),
        .ld_all(ld_all), .ld_sec_only(ld_sec_only), .adj_we(adj_we)
    );

    tod_counter #(.FRAC_W(FRAC_W)) u_counter (
        .clk(clk), .rst(rst), .step(step), .ld_all(ld_all),
        .ld_sec_only(ld_sec_only), .ld_sec(reg_wdata), .ld_ns(pend_ns),
        .ld_frac(pend_frac), .sec_q(ts_sec), .ns_q(ts_ns), .frac_q(frac_q)
    );

    tod_rdsnap #(.FRAC_W(FRAC_W)) u_rdsnap (
        .clk(clk), .rst(rst), .rd_en(reg_rd), .sel(sel),
        .live_sec(ts_sec), .live_ns(ts_ns), .live_frac(frac_q), .adj_q(adj_q),
        .state(rd_state), .shadow_sec(shadow_sec), .shadow_ns(shadow_ns),
        .rdata(reg_rdata)
    );
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
    import tod_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [31:0] ts_sec,
    input logic [31:0] ts_ns,
    input rd_state_e   rd_state,
    input logic [31:0] shadow_sec,
    input logic [31:0] shadow_ns,
    input wr_state_e   wr_state,
    input logic [31:0] pend_ns,
    input logic [31:0] adj_q,
    input logic        ld_all,
    input logic        ld_sec_only
);
    // R3: outside a load, nanoseconds stay below one billion
    a_r3_ns_range: assert property (@(posedge clk) disable iff (rst)
        (!ld_all && ts_ns < BILLION) |=> ts_ns < BILLION);

    // R3: seconds only move by a one-second carry that coincides with a nanosecond wrap
    a_r3_sec_carry: assert property (@(posedge clk) disable iff (rst)
        (!ld_all && !ld_sec_only) |=>
            (ts_sec == $past(ts_sec)) ||
            (ts_sec == $past(ts_sec) + 32'd1 && ts_ns < $past(ts_ns)));

    // R5: the shadow pair is frozen while held, unless a new fraction read comes
    a_r5_snap_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_state == RS_HELD && !(reg_rd && reg_addr == 2'd0)) |=>
            ($stable(shadow_ns) && $stable(shadow_sec)));

    // R7: the seconds write in the armed state loads the parked nanoseconds
    a_r7_commit_load: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2 && wr_state == WS_ARMED) |=>
            (ts_ns == $past(pend_ns) && ts_sec == $past(reg_wdata)));

    // R9: an adjust read returns the adjust word one cycle later
    a_r9_adj_read: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd3) |=> reg_rdata == $past(adj_q));
endmodule

bind tod_clock tod_clock_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ts_sec(ts_sec), .ts_ns(ts_ns), .rd_state(rd_state),
    .shadow_sec(shadow_sec), .shadow_ns(shadow_ns), .wr_state(wr_state),
    .pend_ns(pend_ns), .adj_q(adj_q), .ld_all(ld_all),
    .ld_sec_only(ld_sec_only)
);

// File: tb/tb_tod_clock.sv
`timescale 1ns/1ps
module tb_tod_clock;
    localparam int FRAC_W = 16;
    localparam int NOM_NS = 5;
    localparam longint NOM = longint'(NOM_NS) << FRAC_W;
    localparam longint BIL_F = 64'd1_000_000_000 << FRAC_W;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] ts_sec;
    logic [31:0] ts_ns;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tod_clock #(.FRAC_W(FRAC_W), .NOM_NS(NOM_NS), .NOM_FRAC(0)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ts_sec(ts_sec), .ts_ns(ts_ns)
    );

    // Table rows: adjust word, load seconds, load ns, load fraction, idle cycles
    localparam int NROW = 6;
    localparam logic [31:0] V_ADJ  [NROW] = '{32'h0, 32'h0, 32'h0001_0000,
                                              32'h8000_8000, 32'hFFFF_FFFF, 32'h0};
    localparam logic [31:0] V_SEC  [NROW] = '{32'd7, 32'd41, 32'd1, 32'd2, 32'd3,
                                              32'hFFFF_FFFF};
    localparam logic [31:0] V_NS   [NROW] = '{32'd100, 32'd999_999_990, 32'd0,
                                              32'd1000, 32'd500, 32'd999_999_999};
    localparam logic [31:0] V_FRAC [NROW] = '{32'h0, 32'h0, 32'h8000, 32'h0,
                                              32'h1234, 32'hFFFF};
    localparam int          V_K    [NROW] = '{10, 3, 4, 4, 6, 1};

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d (0x%h) expected %0d (0x%h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic read_time(output logic [31:0] f, output logic [31:0] n,
                             output logic [31:0] s);
        rd(2'd0, f);
        rd(2'd1, n);
        rd(2'd2, s);
    endtask

    // Reference: advance a loaded time by k steps under a given adjust word
    task automatic model(input logic [31:0] s0, input logic [31:0] n0,
                         input logic [31:0] f0, input logic [31:0] adj, input int k,
                         output logic [31:0] s, output logic [31:0] n,
                         output logic [31:0] f);
        longint mag, stp, acc, sec;
        mag = longint'(adj[30:0]);
        if (adj[31]) stp = (mag > NOM) ? 0 : NOM - mag;
        else         stp = NOM + mag;
        acc = (longint'(n0) << FRAC_W) + longint'(f0[FRAC_W-1:0]) + stp * k;
        sec = longint'(s0);
        while (acc >= BIL_F) begin
            acc -= BIL_F;
            sec++;
        end
        s = sec[31:0];
        n = 32'(acc >> FRAC_W);
        f = 32'(acc & ((64'd1 << FRAC_W) - 1));
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] f, n, s, ef, en, es, d;
        idle(3);
        // R1: reset state
        check("R1", "ts_sec in reset", ts_sec, 32'd0);
        check("R1", "ts_ns in reset", ts_ns, 32'd0);
        check("R1", "rdata in reset", reg_rdata, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        rd(2'd3, d);
        check("R1", "adjust after reset", d, 32'd0);

        // Table walk: R2 R3 R4 R5 R10
        for (int i = 0; i < NROW; i++) begin
            wr(2'd3, V_ADJ[i]);
            wr(2'd0, V_FRAC[i]);
            wr(2'd1, V_NS[i]);
            wr(2'd2, V_SEC[i]);
            check("R10", "ts_sec after load", ts_sec, V_SEC[i]);
            check("R10", "ts_ns after load", ts_ns, V_NS[i]);
            idle(V_K[i]);
            read_time(f, n, s);
            model(V_SEC[i], V_NS[i], V_FRAC[i], V_ADJ[i], V_K[i], es, en, ef);
            check("R2/R4", $sformatf("row%0d frac", i), f, ef);
            check("R3/R4", $sformatf("row%0d ns", i), n, en);
            check("R3/R5", $sformatf("row%0d sec", i), s, es);
        end
        wr(2'd3, 32'd0);

        // R5: snapshot survives a long gap
        wr(2'd1, 32'd1000);
        wr(2'd2, 32'd50);
        rd(2'd0, f);
        idle(30);
        rd(2'd1, n);
        rd(2'd2, s);
        check("R5", "held ns after gap", n, 32'd1000);
        check("R5", "held sec after gap", s, 32'd50);
        // R6: released -> live ns (33 steps after load)
        rd(2'd1, n);
        check("R6", "live ns after release", n, 32'd1165);
        // R6: second fraction read replaces the snapshot
        rd(2'd0, f);
        idle(9);
        rd(2'd0, f);
        rd(2'd1, n);
        rd(2'd2, s);
        check("R6", "replaced snapshot ns", n, 32'd1220);
        check("R6", "replaced snapshot sec", s, 32'd50);

        // R7: parked ns does not disturb running time
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd10);
        wr(2'd1, 32'd777);
        idle(5);
        read_time(f, n, s);
        check("R7", "ns while parked", n, 32'd30);
        check("R7", "sec while parked", s, 32'd10);
        wr(2'd2, 32'd11);
        check("R7", "ts_ns on commit", ts_ns, 32'd777);
        check("R7", "ts_sec on commit", ts_sec, 32'd11);
        read_time(f, n, s);
        check("R7", "fraction cleared by commit", f, 32'd0);
        check("R7", "committed ns", n, 32'd777);

        // R8: seconds-only write keeps ns counting (4 steps since commit)
        wr(2'd2, 32'd20);
        read_time(f, n, s);
        check("R8", "ns after seconds-only write", n, 32'd797);
        check("R8", "sec after seconds-only write", s, 32'd20);

        // R9: adjust readback
        wr(2'd3, 32'h8000_1234);
        rd(2'd3, d);
        check("R9", "adjust readback", d, 32'h8000_1234);
        wr(2'd3, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule